// File: doc/BRIEF.md
# Status Channel Training Sequencer

This block handles the deskew training pattern on a two-bit, source-synchronous status channel of the SPI-4 kind. The channel carries one sample on each clock edge, so the block works on two sample lanes per clock: lane 0 is the earlier (rising-edge) sample and lane 1 the later (falling-edge) sample of each clock period. Only the low two bits of each status lane take part in training. Any wider bits carry ordinary calendar data.

On the transmit side, a one-cycle request replaces the normal calendar data with a training burst. The burst is built from a 20-sample unit: ten samples with the low bits at 00, then ten samples with the low bits at 11. The unit is repeated alpha times, and alpha is a programmable repeat count. When the burst ends, the output returns to calendar data and a done pulse is given.

On the receive side, the block watches the incoming samples. When it sees ten consecutive samples whose low bits are zero, it issues a deskew-start pulse and sets a sticky trained flag. Software can suppress detection with an ignore bit, and it clears the flag with a write-one-to-clear input.

Top module: `stat_train_seq`

## Requirements
- R1: After reset, tx_busy_o, tx_done_o, deskew_start_o and rx_trained_o are 0, and tx_stat_o equals cal_data_i.
- R2: A train_req_i high at a clock edge while the transmitter is idle sets tx_busy_o from the next cycle. tx_busy_o then stays high for exactly 10×alpha cycles, which is 20×alpha samples.
- R3: While busy, both lanes carry the same low bits. In each 20-sample unit, samples 0 to 9 carry 2'b00 and samples 10 to 19 carry 2'b11. In clock terms, cycles 0 to 4 of every 10-cycle group carry 00 and cycles 5 to 9 carry 11.
- R4: Alpha is captured when the burst starts, and a later change to alpha_i does not alter that burst. A programmed alpha of 0 is treated as 1.
- R5: In the cycle after the last training cycle, tx_busy_o is 0, tx_done_o is 1 for exactly one cycle, and tx_stat_o again equals cal_data_i. A train_req_i that arrives while busy is ignored.
- R6: While busy, status bits above [1:0] in each lane are driven 0.
- R7: Ten consecutive received samples with bits [1:0] equal to 00 raise deskew_start_o for one cycle. The pulse appears in the cycle after the clock edge that samples the tenth zero. The count follows sample order, lane 0 before lane 1, and may cross clock boundaries. Bits above [1:0] are ignored.
- R8: A received sample with nonzero bits [1:0] resets the zero-run count, so a run of nine zeros gives no pulse.
- R9: After a detection, no further pulse is given until a nonzero sample has been seen.
- R10: While ignore_train_i is 1, a zero run gives no pulse and does not set rx_trained_o.
- R11: rx_trained_o is set together with each deskew pulse. rx_trained_clr_i clears it. If a set and a clear occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle carries two samples |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_data_i | input | 2*STAT_W | Normal calendar status, lane 0 in the low STAT_W bits |
| train_req_i | input | 1 | One-cycle request to send a training burst |
| alpha_i | input | ALPHA_W | Unit repeat count (0 is treated as 1) |
| tx_stat_o | output | 2*STAT_W | Transmitted status, two lanes |
| tx_busy_o | output | 1 | Training burst in progress |
| tx_done_o | output | 1 | One-cycle pulse at the end of a burst |
| rx_stat_i | input | 2*STAT_W | Received status samples, lane 0 in the low STAT_W bits |
| ignore_train_i | input | 1 | Suppresses training detection |
| rx_trained_clr_i | input | 1 | Write-one-to-clear for rx_trained_o |
| deskew_start_o | output | 1 | One-cycle pulse that starts deskew |
| rx_trained_o | output | 1 | Sticky flag: training was detected |

## Verification
The assertions check the following on every cycle:
- while busy, the pattern holds only 00 or 11 and both lanes agree;
- a request to an idle transmitter raises busy;
- busy falls exactly when done pulses;
- done and deskew pulses are single-cycle;
- an ignore bit blocks the next cycle's pulse;
- the sticky flag is present with every pulse.

Only the bench scenarios can show the following:
- the exact burst length for several alpha values, including 0;
- the exact cycle of each detection, including a tenth zero that lands in lane 0 mid-cycle;
- that a nine-sample run does not fire;
- re-arming after a nonzero sample;
- that the upper status bits have no effect.

// File: rtl/stat_train_pkg.sv
package stat_train_pkg;
  localparam int unsigned LANES      = 2;   // samples per clock (both edges)
  localparam int unsigned TRAIN_BITS = 2;   // status bits taking part in training
  localparam int unsigned RUN_LEN    = 10;  // samples per zero or ones run
  localparam int unsigned RUN_PAIRS  = RUN_LEN / LANES;
  localparam int unsigned UNIT_PAIRS = 2 * RUN_PAIRS;
  localparam int unsigned PAIR_W     = $clog2(UNIT_PAIRS);
  localparam int unsigned RUN_CNT_W  = $clog2(RUN_LEN + 1);
endpackage

// File: rtl/stat_tx_gen.sv
module stat_tx_gen
  import stat_train_pkg::*;
#(
  parameter int unsigned ALPHA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  output logic               busy_o,
  output logic               ones_o,
  output logic               done_o
);
  logic [PAIR_W-1:0]  pair_q;
  logic [ALPHA_W-1:0] rep_q, alpha_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      pair_q  <= '0;
      rep_q   <= '0;
      alpha_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (req_i) begin
          busy_o  <= 1'b1;
          pair_q  <= '0;
          rep_q   <= '0;
          alpha_q <= (alpha_i == '0) ? ALPHA_W'(1) : alpha_i;
        end
      end else if (pair_q == PAIR_W'(UNIT_PAIRS - 1)) begin
        pair_q <= '0;
        if (rep_q == alpha_q - ALPHA_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          rep_q <= rep_q + ALPHA_W'(1);
        end
      end else begin
        pair_q <= pair_q + PAIR_W'(1);
      end
    end
  end

  // run length is even, so both samples of a clock share a phase
  assign ones_o = (pair_q >= PAIR_W'(RUN_PAIRS));
endmodule

// File: rtl/stat_rx_det.sv
module stat_rx_det
  import stat_train_pkg::*;
#(
  parameter int unsigned STAT_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LANES*STAT_W-1:0]   stat_i,
  input  logic                      ignore_i,
  input  logic                      clr_i,
  output logic                      start_o,
  output logic                      trained_o
);
  logic [RUN_CNT_W-1:0] run_q, run_d;
  logic                 hit;

  // lane 0 is the earlier sample
  always_comb begin
    run_d = run_q;
    hit   = 1'b0;
    for (int l = 0; l < int'(LANES); l++) begin
      if (stat_i[l*STAT_W +: TRAIN_BITS] != '0) begin
        run_d = '0;
      end else if (run_d < RUN_CNT_W'(RUN_LEN)) begin
        run_d = run_d + RUN_CNT_W'(1);
        if (run_d == RUN_CNT_W'(RUN_LEN)) hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      start_o   <= 1'b0;
      trained_o <= 1'b0;
    end else begin
      run_q   <= run_d;
      start_o <= hit && !ignore_i;
      if (hit && !ignore_i) trained_o <= 1'b1;
      else if (clr_i)       trained_o <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_train_seq.sv
module stat_train_seq
  import stat_train_pkg::*;
#(
  parameter int unsigned STAT_W  = 4,
  parameter int unsigned ALPHA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2*STAT_W-1:0]     cal_data_i,
  input  logic                    train_req_i,
  input  logic [ALPHA_W-1:0]      alpha_i,
  output logic [2*STAT_W-1:0]     tx_stat_o,
  output logic                    tx_busy_o,
  output logic                    tx_done_o,
  input  logic [2*STAT_W-1:0]     rx_stat_i,
  input  logic                    ignore_train_i,
  input  logic                    rx_trained_clr_i,
  output logic                    deskew_start_o,
  output logic                    rx_trained_o
);
  logic tx_ones;

  stat_tx_gen #(.ALPHA_W(ALPHA_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (train_req_i),
    .alpha_i(alpha_i),
    .busy_o (tx_busy_o),
    .ones_o (tx_ones),
    .done_o (tx_done_o)
  );

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    logic [STAT_W-1:0] pat;
    always_comb begin
      pat = '0;
      pat[TRAIN_BITS-1:0] = tx_ones ? '1 : '0;
    end
    assign tx_stat_o[g*STAT_W +: STAT_W] =
      tx_busy_o ? pat : cal_data_i[g*STAT_W +: STAT_W];
  end

  stat_rx_det #(.STAT_W(STAT_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stat_i   (rx_stat_i),
    .ignore_i (ignore_train_i),
    .clr_i    (rx_trained_clr_i),
    .start_o  (deskew_start_o),
    .trained_o(rx_trained_o)
  );
endmodule

// File: rtl/stat_train_chk.sv
module stat_train_chk #(
  parameter int unsigned STAT_W  = 4,
  parameter int unsigned ALPHA_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*STAT_W-1:0] cal_data_i,
  input logic                train_req_i,
  input logic [ALPHA_W-1:0]  alpha_i,
  input logic [2*STAT_W-1:0] tx_stat_o,
  input logic                tx_busy_o,
  input logic                tx_done_o,
  input logic [2*STAT_W-1:0] rx_stat_i,
  input logic                ignore_train_i,
  input logic                rx_trained_clr_i,
  input logic                deskew_start_o,
  input logic                rx_trained_o
);
  // R2
  req_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_req_i && !tx_busy_o) |=> tx_busy_o);
  // R3
  pattern_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_o |-> (tx_stat_o[1:0] == tx_stat_o[STAT_W+1:STAT_W]) &&
                  (tx_stat_o[1:0] == 2'b00 || tx_stat_o[1:0] == 2'b11));
  // R5
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_busy_o) |-> tx_done_o);
  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);
  // R9
  deskew_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deskew_start_o |=> !deskew_start_o);
  // R10
  ignore_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignore_train_i |=> !deskew_start_o);
  // R11
  sticky_with_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deskew_start_o |-> rx_trained_o);
endmodule

bind stat_train_seq stat_train_chk #(.STAT_W(STAT_W), .ALPHA_W(ALPHA_W)) u_chk (.*);

// File: tb/tb_stat_train_seq.sv
module tb_stat_train_seq;
  localparam int unsigned STAT_W  = 4;
  localparam int unsigned ALPHA_W = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [2*STAT_W-1:0] cal_data = 8'hA5;
  logic                req = 1'b0;
  logic [ALPHA_W-1:0]  alpha = '0;
  logic [2*STAT_W-1:0] tx_stat;
  logic                busy, done;
  logic [2*STAT_W-1:0] rx_stat = 8'h11;
  logic                ignore = 1'b0;
  logic                clr = 1'b0;
  logic                deskew, trained;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  stat_train_seq #(.STAT_W(STAT_W), .ALPHA_W(ALPHA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cal_data_i(cal_data), .train_req_i(req),
    .alpha_i(alpha), .tx_stat_o(tx_stat), .tx_busy_o(busy), .tx_done_o(done),
    .rx_stat_i(rx_stat), .ignore_train_i(ignore), .rx_trained_clr_i(clr),
    .deskew_start_o(deskew), .rx_trained_o(trained)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R1
  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(deskew == 1'b0, "R1 deskew", deskew, 0);
    chk(trained == 1'b0, "R1 trained", trained, 0);
    chk(tx_stat == cal_data, "R1 tx_stat", tx_stat, cal_data);
  endtask

  // R2 R3 R4 R5 R6
  task automatic run_burst(input int a_prog, input int a_eff, input bit disturb);
    int bad = 0;
    logic [STAT_W-1:0] ln;
    @(negedge clk); alpha = ALPHA_W'(a_prog); req = 1'b1;
    for (int k = 0; k < 10 * a_eff; k++) begin
      if (k > 0) begin
        @(negedge clk); req = 1'b0;
        if (disturb && k == 3) begin req = 1'b1; alpha = 8'd1; end
      end
      @(posedge clk); #1;
      ln = ((k % 10) < 5) ? 4'b0000 : 4'b0011;
      if (!busy || done) bad++;
      chk(tx_stat == {ln, ln}, "R3 R6 pattern", tx_stat, {ln, ln});
    end
    chk(bad == 0, "R2 busy held", bad, 0);
    @(negedge clk); req = 1'b0;
    @(posedge clk); #1;
    chk(busy == 1'b0, "R2 R4 busy end", busy, 0);
    chk(done == 1'b1, "R5 done", done, 1);
    chk(tx_stat == cal_data, "R5 cal restored", tx_stat, cal_data);
    @(negedge clk);
    @(posedge clk); #1;
    chk(done == 1'b0, "R5 done single", done, 0);
    chk(busy == 1'b0, "R5 no restart", busy, 0);
  endtask

  task automatic rxp(input logic [3:0] l0, input logic [3:0] l1, input logic c,
                     input logic exp_ds, input string tag);
    @(negedge clk); rx_stat = {l1, l0}; clr = c;
    @(posedge clk); #1;
    chk(deskew == exp_ds, tag, deskew, exp_ds);
  endtask

  // R7 R9
  task automatic t_detect();
    rxp(4'h1, 4'h2, 0, 0, "R7 nonzero");
    for (int i = 0; i < 4; i++) rxp(4'hC, 4'h4, 0, 0, "R7 partial run");
    rxp(4'h8, 4'hC, 0, 1, "R7 tenth zero");
    chk(trained == 1'b1, "R11 sticky set", trained, 1);
    for (int i = 0; i < 3; i++) rxp(4'h0, 4'h0, 0, 0, "R9 no refire");
    rxp(4'h3, 4'h3, 0, 0, "R9 rearm");
    for (int i = 0; i < 4; i++) rxp(4'h0, 4'h0, 0, 0, "R9 run");
    rxp(4'h0, 4'h0, 0, 1, "R9 refire");
  endtask

  // R8 R7 odd alignment
  task automatic t_reset_run();
    rxp(4'h1, 4'h0, 0, 0, "R8 start lane1");
    for (int i = 0; i < 4; i++) rxp(4'h0, 4'h0, 0, 0, "R8 nine zeros");
    rxp(4'h2, 4'h0, 0, 0, "R8 nonzero breaks run");
    for (int i = 0; i < 4; i++) rxp(4'h0, 4'h0, 0, 0, "R8 nine again");
    rxp(4'h0, 4'h1, 0, 1, "R7 tenth in lane0");
  endtask

  // R11
  task automatic t_clear();
    rxp(4'h1, 4'h1, 1, 0, "R11 clear");
    chk(trained == 1'b0, "R11 cleared", trained, 0);
    for (int i = 0; i < 4; i++) rxp(4'h0, 4'h0, 0, 0, "R11 run");
    rxp(4'h0, 4'h0, 1, 1, "R11 set with clear");
    chk(trained == 1'b1, "R11 set wins", trained, 1);
    rxp(4'h1, 4'h1, 1, 0, "R11 clear2");
  endtask

  // R10
  task automatic t_ignore();
    ignore = 1'b1;
    for (int i = 0; i < 6; i++) rxp(4'h0, 4'h0, 0, 0, "R10 ignored");
    chk(trained == 1'b0, "R10 no sticky", trained, 0);
    rxp(4'h1, 4'h1, 0, 0, "R10 break");
    ignore = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; t_reset();
    run_burst(2, 2, 0);
    run_burst(0, 1, 0);   // R4 alpha 0
    run_burst(3, 3, 1);   // R4 R5 mid-burst request and alpha change
    t_detect();
    t_reset_run();
    t_clear();
    t_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule